// File: doc/BRIEF.md
# Interrupt Status Enable Mask Bank

This block collects hardware event signals into a small set of bus-visible registers and reduces them to one interrupt line. A four-bit status register holds a sticky event flag in bit 0, which software clears by reading it, and three hardware-owned state bits above it. A four-bit enable register qualifies the status bits. A separate 32-bit pending register is set by hardware, bit by bit, and cleared by software writing ones. A 32-bit mask register suppresses individual pending bits.

Software reaches the four registers through a word-addressed register bus with separate read and write strobes and combinational read data. Hardware can load the status state bits, the enable register and the mask register directly. The qualified status bits and the unmasked pending bits are reduced separately and then ORed into the interrupt output.

Top module: `irqbank_top`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is low.
- R2: Status, enable, mask and pending sit at word addresses BASE+0, BASE+1, BASE+2 and BASE+3 (BASE defaults to 0x16010). A read of any other address returns 0, and a write to any other address changes no register.
- R3: `evt_flag` high at a clock edge sets status bit 0. A read of the status address returns the current value, and bit 0 is cleared at the edge that ends the read cycle.
- R4: If `evt_flag` is high in the same cycle as a clearing read of the status address, status bit 0 remains set after that edge.
- R5: Status bits 3:1 load `hw_stat_d` when `hw_stat_we` is high and otherwise hold. Software writes to the status address have no effect. Status read bits 31:4 are 0.
- R6: Enable bits 3:0 are written by a software write (data bits 3:0) or by `hw_en_we` with `hw_en_d`. The hardware load wins when both happen in the same cycle. Enable read bits 31:4 are 0.
- R7: The 32-bit mask register is written by software or by `hw_mask_we` with `hw_mask_d`. The hardware load wins when both happen in the same cycle.
- R8: A 1 in `hw_pend_set` sets that pending bit. A software write with a 1 in a bit position clears that pending bit. A hardware set beats a software clear of the same bit in the same cycle.
- R9: Writing 0 to a pending bit leaves it unchanged.
- R10: `irq_out` is high exactly when some status bit i has enable bit i set, or some pending bit is 1 with its mask bit 0. It follows the register state with no added delay.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| evt_flag | input | 1 | Sets status bit 0 |
| hw_stat_we | input | 1 | Hardware load of status bits 3:1 |
| hw_stat_d | input | NSTAT-1 | Value for status bits 3:1 |
| hw_en_we | input | 1 | Hardware load of enable |
| hw_en_d | input | NSTAT | Value for enable |
| hw_mask_we | input | 1 | Hardware load of mask |
| hw_mask_d | input | 32 | Value for mask |
| hw_pend_set | input | 32 | Per-bit pending set |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench targets an event that arrives in the same cycle as the clearing status read. A design that got this wrong would lose the event. It also targets a hardware set that collides with a software clear of the same pending bit, where the failure is a dropped pending bit. It drives writes of zero and writes to the read-only status and out-of-range addresses, which a faulty decode would let corrupt state. It also sweeps every status/enable pairing and every single mask and pending bit, so a wrong gating polarity or a bit-lane swap shows up on `irq_out` or in readback.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 4;
  localparam int OFF_W    = $clog2(NUM_REGS);

  // Word offsets from the base address
  localparam int IDX_STAT = 0;
  localparam int IDX_EN   = 1;
  localparam int IDX_MASK = 2;
  localparam int IDX_PEND = 3;

  typedef logic [WORD_W-1:0] word_t;

  // Write-one-to-clear with set dominating the clear
  function automatic word_t w1c_update(word_t cur, word_t clr, word_t set);
    return (cur & ~clr) | set;
  endfunction

  // Clear-on-read flag; a new event overrides the clear
  function automatic logic roc_update(logic cur, logic clr, logic set);
    return set | (cur & ~clr);
  endfunction

  // Two separately gated reductions, then ORed
  function automatic logic irq_combine(word_t stat, word_t en, word_t pend, word_t mask);
    return (|(stat & en)) | (|(pend & ~mask));
  endfunction
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
  import irqbank_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE = 20'h16010
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic                rd,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [NUM_REGS-1:0] rd_sel
);
  logic hit;
  assign hit = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel[g] = wr & hit & (addr[OFF_W-1:0] == OFF_W'(g));
    assign rd_sel[g] = rd & hit & (addr[OFF_W-1:0] == OFF_W'(g));
  end
endmodule

// File: rtl/irqbank_rwreg.sv
module irqbank_rwreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_we,
  input  logic [W-1:0] hw_d,
  input  logic         sw_we,
  input  logic [W-1:0] sw_d,
  output logic [W-1:0] q
);
  // Hardware load has priority over a software write
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (hw_we) q <= hw_d;
    else if (sw_we) q <= sw_d;
  end
endmodule

// File: rtl/irqbank_status.sv
module irqbank_status
  import irqbank_pkg::*;
#(
  parameter int NSTAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             rd_clr,
  input  logic             hw_we,
  input  logic [NSTAT-1:1] hw_d,
  output logic [NSTAT-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q[0] <= 1'b0;
    else        stat_q[0] <= roc_update(stat_q[0], rd_clr, evt);
  end

  for (genvar g = 1; g < NSTAT; g++) begin : g_hwbit
    always_ff @(posedge clk) begin
      if (!rst_n)     stat_q[g] <= 1'b0;
      else if (hw_we) stat_q[g] <= hw_d[g];
    end
  end
endmodule

// File: rtl/irqbank_pend.sv
module irqbank_pend
  import irqbank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_vec,
  input  word_t clr_vec,
  output word_t pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= w1c_update(pend_q, clr_vec, set_vec);
  end
endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
  import irqbank_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE = 20'h16010,
  parameter int NSTAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_flag,
  input  logic              hw_stat_we,
  input  logic [NSTAT-1:1]  hw_stat_d,
  input  logic              hw_en_we,
  input  logic [NSTAT-1:0]  hw_en_d,
  input  logic              hw_mask_we,
  input  logic [31:0]       hw_mask_d,
  input  logic [31:0]       hw_pend_set,
  output logic              irq_out
);
  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_REGS-1:0] rd_sel;

  // Named internal events, also watched by the checker
  logic stat_rd_clr;
  logic stat_wr;
  logic pend_wr;
  word_t pend_clr_vec;

  logic [NSTAT-1:0] status_q;
  logic [NSTAT-1:0] en_q;
  word_t mask_q;
  word_t pend_q;
  word_t status_w;
  word_t en_w;

  irqbank_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  assign stat_rd_clr  = rd_sel[IDX_STAT];
  assign stat_wr      = wr_sel[IDX_STAT];
  assign pend_wr      = wr_sel[IDX_PEND];
  assign pend_clr_vec = pend_wr ? bus_wdata : '0;

  irqbank_status #(.NSTAT(NSTAT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_flag),
    .rd_clr (stat_rd_clr),
    .hw_we  (hw_stat_we),
    .hw_d   (hw_stat_d),
    .stat_q (status_q)
  );

  irqbank_rwreg #(.W(NSTAT)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .hw_we (hw_en_we),
    .hw_d  (hw_en_d),
    .sw_we (wr_sel[IDX_EN]),
    .sw_d  (bus_wdata[NSTAT-1:0]),
    .q     (en_q)
  );

  irqbank_rwreg #(.W(WORD_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .hw_we (hw_mask_we),
    .hw_d  (hw_mask_d),
    .sw_we (wr_sel[IDX_MASK]),
    .sw_d  (bus_wdata),
    .q     (mask_q)
  );

  irqbank_pend u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (hw_pend_set),
    .clr_vec (pend_clr_vec),
    .pend_q  (pend_q)
  );

  assign status_w = WORD_W'(status_q);
  assign en_w     = WORD_W'(en_q);

  // AND-OR read mux; all zero when no select is active
  assign bus_rdata = ({WORD_W{rd_sel[IDX_STAT]}} & status_w)
                   | ({WORD_W{rd_sel[IDX_EN]}}   & en_w)
                   | ({WORD_W{rd_sel[IDX_MASK]}} & mask_q)
                   | ({WORD_W{rd_sel[IDX_PEND]}} & pend_q);

  assign irq_out = irq_combine(status_w, en_w, pend_q, mask_q);
endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
  parameter int NSTAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_flag,
  input logic             hw_stat_we,
  input logic [31:0]      hw_pend_set,
  input logic [31:0]      bus_wdata,
  input logic             stat_rd_clr,
  input logic             stat_wr,
  input logic             pend_wr,
  input logic [NSTAT-1:0] status_q,
  input logic [NSTAT-1:0] en_q,
  input logic [31:0]      mask_q,
  input logic [31:0]      pend_q,
  input logic             irq_out
);
  a_r3_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag |=> status_q[0]);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && !evt_flag) |=> !status_q[0]);

  a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && evt_flag) |=> status_q[0]);

  a_r5_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !hw_stat_we) |=> $stable(status_q[NSTAT-1:1]));

  a_r8_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend_q & $past(bus_wdata & ~hw_pend_set)) == 32'h0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_pend_set) |=> ((pend_q & $past(hw_pend_set)) == $past(hw_pend_set)));

  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((($past(pend_q) & ~$past(bus_wdata)) & ~pend_q) == 32'h0));

  a_r10_pend_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~mask_q)) |-> irq_out);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (((status_q & en_q) == '0) && ((pend_q & ~mask_q) == 32'h0)) |-> !irq_out);
endmodule

bind irqbank_top irqbank_chk #(.NSTAT(NSTAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_flag    (evt_flag),
  .hw_stat_we  (hw_stat_we),
  .hw_pend_set (hw_pend_set),
  .bus_wdata   (bus_wdata),
  .stat_rd_clr (stat_rd_clr),
  .stat_wr     (stat_wr),
  .pend_wr     (pend_wr),
  .status_q    (status_q),
  .en_q        (en_q),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .irq_out     (irq_out)
);

// File: tb/sim_irqbank_top.sv
module sim_irqbank_top;
  localparam int ADDR_W = 20;
  localparam logic [19:0] BASE = 20'h16010;
  localparam logic [19:0] A_STAT = BASE;
  localparam logic [19:0] A_EN   = BASE + 20'd1;
  localparam logic [19:0] A_MASK = BASE + 20'd2;
  localparam logic [19:0] A_PEND = BASE + 20'd3;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz
  logic rst_n;

  // applied inputs
  logic [19:0] a_addr; logic a_wr, a_rd; logic [31:0] a_wdata;
  logic a_evt, a_swe; logic [3:1] a_sd; logic a_ewe; logic [3:0] a_ed;
  logic a_mwe; logic [31:0] a_md; logic [31:0] a_pset;
  // next inputs
  logic [19:0] n_addr; logic n_wr, n_rd; logic [31:0] n_wdata;
  logic n_evt, n_swe; logic [3:1] n_sd; logic n_ewe; logic [3:0] n_ed;
  logic n_mwe; logic [31:0] n_md; logic [31:0] n_pset;

  logic [31:0] rdata;
  logic irq;

  // reference state
  logic [3:0] m_stat, m_en;
  logic [31:0] m_mask, m_pend;
  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  irqbank_top #(.ADDR_W(ADDR_W), .BASE(BASE), .NSTAT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr), .bus_rd(a_rd),
    .bus_wdata(a_wdata), .bus_rdata(rdata), .evt_flag(a_evt),
    .hw_stat_we(a_swe), .hw_stat_d(a_sd), .hw_en_we(a_ewe), .hw_en_d(a_ed),
    .hw_mask_we(a_mwe), .hw_mask_d(a_md), .hw_pend_set(a_pset), .irq_out(irq)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_next();
    n_addr = 20'h0; n_wr = 0; n_rd = 0; n_wdata = 0; n_evt = 0; n_swe = 0;
    n_sd = 0; n_ewe = 0; n_ed = 0; n_mwe = 0; n_md = 0; n_pset = 0;
  endtask

  task automatic cyc(input string tag);
    logic hit; logic [1:0] off; logic [31:0] exp; string t;
    @(negedge clk);
    a_addr = n_addr; a_wr = n_wr; a_rd = n_rd; a_wdata = n_wdata; a_evt = n_evt;
    a_swe = n_swe; a_sd = n_sd; a_ewe = n_ewe; a_ed = n_ed; a_mwe = n_mwe;
    a_md = n_md; a_pset = n_pset;
    #2;
    hit = (a_addr >= BASE) && (a_addr <= BASE + 20'd3);
    off = 2'(a_addr - BASE);
    exp = 32'h0;
    t = "R11";
    if (a_rd && !hit) t = "R2";
    if (a_rd && hit) begin
      case (off)
        2'd0: begin exp = {28'h0, m_stat}; t = "R3 R5"; end
        2'd1: begin exp = {28'h0, m_en};   t = "R6"; end
        2'd2: begin exp = m_mask;          t = "R7"; end
        default: begin exp = m_pend;       t = "R8"; end
      endcase
    end
    if (tag != "") t = tag;
    check(t, rdata, exp);
    check("R10 irq", {31'h0, irq},
          {31'h0, ((m_stat & m_en) != 4'h0) || ((m_pend & ~m_mask) != 32'h0)});
    @(posedge clk);
    if (a_evt) m_stat[0] = 1'b1;
    else if (a_rd && hit && off == 2'd0) m_stat[0] = 1'b0;
    if (a_swe) m_stat[3:1] = a_sd;
    if (a_ewe) m_en = a_ed;
    else if (a_wr && hit && off == 2'd1) m_en = a_wdata[3:0];
    if (a_mwe) m_mask = a_md;
    else if (a_wr && hit && off == 2'd2) m_mask = a_wdata;
    for (int b = 0; b < 32; b++) begin
      if (a_pset[b]) m_pend[b] = 1'b1;
      else if (a_wr && hit && off == 2'd3 && a_wdata[b]) m_pend[b] = 1'b0;
    end
  endtask

  task automatic rd(input logic [19:0] addr, input string tag);
    clr_next(); n_rd = 1; n_addr = addr; cyc(tag);
  endtask

  task automatic wr(input logic [19:0] addr, input logic [31:0] d, input string tag);
    clr_next(); n_wr = 1; n_addr = addr; n_wdata = d; cyc(tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clr_next();
    a_addr = 0; a_wr = 0; a_rd = 0; a_wdata = 0; a_evt = 0; a_swe = 0; a_sd = 0;
    a_ewe = 0; a_ed = 0; a_mwe = 0; a_md = 0; a_pset = 0;
    m_stat = 0; m_en = 0; m_mask = 0; m_pend = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset values
    rd(A_STAT, "R1"); rd(A_EN, "R1"); rd(A_MASK, "R1"); rd(A_PEND, "R1");
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R3: set, read returns 1, then cleared
    clr_next(); n_evt = 1; cyc("");
    rd(A_STAT, "R3"); rd(A_STAT, "R3");
    // R4: event collides with clearing read
    clr_next(); n_evt = 1; cyc("");
    clr_next(); n_evt = 1; n_rd = 1; n_addr = A_STAT; cyc("R4");
    rd(A_STAT, "R4"); rd(A_STAT, "R4");

    // R5: software write to status ignored, hardware load visible
    wr(A_STAT, 32'hFFFF_FFFF, "R5"); rd(A_STAT, "R5");
    clr_next(); n_swe = 1; n_sd = 3'b101; cyc("");
    rd(A_STAT, "R5");
    wr(A_STAT, 32'h0, "R5"); rd(A_STAT, "R5");
    clr_next(); n_swe = 1; n_sd = 3'b000; cyc("");

    // R6: enable width and hardware priority
    wr(A_EN, 32'hFFFF_FFFF, "R6"); rd(A_EN, "R6");
    clr_next(); n_wr = 1; n_addr = A_EN; n_wdata = 32'h5; n_ewe = 1; n_ed = 4'hA; cyc("R6");
    rd(A_EN, "R6");
    wr(A_EN, 32'h0, "R6");

    // R2: out-of-range accesses
    wr(BASE + 20'd4, 32'hFFFF_FFFF, "R2"); wr(BASE - 20'd1, 32'hFFFF_FFFF, "R2");
    rd(BASE + 20'd4, "R2"); rd(BASE - 20'd1, "R2");
    rd(A_EN, "R2"); rd(A_MASK, "R2");

    // R7: hardware beats software on mask
    clr_next(); n_wr = 1; n_addr = A_MASK; n_wdata = 32'h1111_1111;
    n_mwe = 1; n_md = 32'hCAFE_0001; cyc("R7");
    rd(A_MASK, "R7"); wr(A_MASK, 32'h0, "R7");

    // R7/R8/R9/R10: per-bit sweep of mask and pending
    for (int i = 0; i < 32; i++) begin
      clr_next(); n_pset = 32'h1 << i; cyc("");
      rd(A_PEND, "R8");
      wr(A_MASK, 32'h1 << i, "R7"); rd(A_MASK, "R7");
      rd(A_MASK, "R10");
      wr(A_MASK, 32'h0, "R7");
      wr(A_PEND, ~(32'h1 << i), "R9"); rd(A_PEND, "R9");
      wr(A_PEND, 32'h1 << i, "R8"); rd(A_PEND, "R8");
      clr_next(); n_pset = 32'h1 << i; n_wr = 1; n_addr = A_PEND; n_wdata = 32'hFFFF_FFFF; cyc("R8");
      rd(A_PEND, "R8");
      wr(A_PEND, 32'hFFFF_FFFF, "R8");
    end

    // R10: every status/enable pairing
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        clr_next(); n_rd = 1; n_addr = A_STAT; n_swe = 1; n_sd = 3'(s >> 1);
        n_ewe = 1; n_ed = 4'(e); cyc("");
        if (s[0]) begin clr_next(); n_evt = 1; cyc(""); end
        clr_next(); cyc("R10");
      end
    end

    // mixed pseudo-random traffic against the reference state
    for (int k = 0; k < 2500; k++) begin
      logic [31:0] x, y, z;
      rng = nxt(rng); x = rng;
      rng = nxt(rng); y = rng;
      rng = nxt(rng); z = rng;
      clr_next();
      n_addr = BASE - 20'd1 + 20'(x[2:0]);
      n_rd = x[3]; n_wr = x[4]; n_wdata = y;
      n_evt = x[5] & x[6]; n_swe = x[7] & x[8]; n_sd = x[11:9];
      n_ewe = x[12] & x[13]; n_ed = x[17:14];
      n_mwe = x[18] & x[19] & x[20]; n_md = z;
      n_pset = y & z & nxt(z) & {32{x[21]}};
      cyc("");
    end

    summary();
    $finish;
  end
endmodule